// File: doc/BRIEF.md
# Integer Execute Unit with Immediate Operand Handling

This block is the purely combinational execute stage of a small 32-bit load/store RISC core. Each cycle it takes a 6-bit primary opcode, a 6-bit function code, two register operands and a 16-bit immediate. It produces a 32-bit result and a memory address. It holds no state, so it has neither a clock nor a reset.

Register-register forms use primary opcode 0, and the function code picks the operation. Immediate forms are picked by the primary opcode alone. Arithmetic and comparison immediates are sign-extended. Logical immediates are zero-extended. An address generator runs next to the ALU on every cycle and adds the sign-extended immediate to the first register operand, which serves word loads and word stores. Add and subtract wrap modulo 2^32 and report no overflow. Any encoding not listed below returns a zero result and raises an illegal-operation flag.

Top module: `alu_exec`

## Requirements
- R1: With opcode 0, function code 32 returns rs+rt and function code 34 returns rs-rt, both taken modulo 2^32.
- R2: With opcode 0, function codes 36, 37, 38 and 39 return bitwise AND, OR, XOR and NOR of rs and rt. NOR of zero with zero is all ones.
- R3: With opcode 0, function code 42 returns 1 when rs is less than rt as signed two's-complement values, and returns 0 otherwise. Bits 31:1 of the result are always zero.
- R4: Opcode 8 returns rs plus the sign-extended immediate, modulo 2^32. Opcode 10 returns 1 when rs is signed-less-than the sign-extended immediate, and 0 otherwise.
- R5: Opcodes 12, 13 and 14 return AND, OR and XOR of rs with the zero-extended immediate.
- R6: Opcode 15 returns the immediate in bits 31:16 with bits 15:0 cleared.
- R7: addr_o always equals rs plus the sign-extended immediate, modulo 2^32. Opcodes 35 (load word) and 43 (store word) are legal and return a zero result.
- R8: Any other opcode, and opcode 0 with any other function code, returns a zero result with illegal_o high. Every listed encoding keeps illegal_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | 6 | Primary opcode |
| fn_i | input | 6 | Function code, used only when opcode is 0 |
| rs_val_i | input | 32 | First register operand, also the address base |
| rt_val_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate or address offset |
| result_o | output | 32 | Operation result |
| addr_o | output | 32 | Effective address for loads and stores |
| illegal_o | output | 1 | High for an unlisted encoding |

## Verification
The block holds no state, so any fault in its decode or operand selection shows on the ports in the same cycle as the input that triggers it. A wrong extension mode shows as a changed upper half whenever the immediate has bit 15 set. A wrong decode shows as a result from the wrong operation, or as a flipped illegal flag. The sweep drives every opcode against every function code, then drives every legal encoding against operands at the sign boundaries. This covers each decode entry and both extension paths.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

  localparam int unsigned OPC_W = 6;
  localparam int unsigned FN_W  = 6;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'd0;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'd8;
  localparam logic [OPC_W-1:0] OPC_SLTI  = 6'd10;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'd12;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'd13;
  localparam logic [OPC_W-1:0] OPC_XORI  = 6'd14;
  localparam logic [OPC_W-1:0] OPC_LUI   = 6'd15;
  localparam logic [OPC_W-1:0] OPC_LW    = 6'd35;
  localparam logic [OPC_W-1:0] OPC_SW    = 6'd43;

  localparam logic [FN_W-1:0] FN_ADD = 6'd32;
  localparam logic [FN_W-1:0] FN_SUB = 6'd34;
  localparam logic [FN_W-1:0] FN_AND = 6'd36;
  localparam logic [FN_W-1:0] FN_OR  = 6'd37;
  localparam logic [FN_W-1:0] FN_XOR = 6'd38;
  localparam logic [FN_W-1:0] FN_NOR = 6'd39;
  localparam logic [FN_W-1:0] FN_SLT = 6'd42;

  typedef enum logic [3:0] {
    ALU_NONE, ALU_ADD, ALU_SUB, ALU_SLT, ALU_AND,
    ALU_OR, ALU_XOR, ALU_NOR, ALU_LUI
  } alu_op_e;

  typedef enum logic [1:0] {
    IMM_NONE, IMM_SEXT, IMM_ZEXT
  } imm_mode_e;

  typedef struct packed {
    alu_op_e   op;
    imm_mode_e imm_mode;
    logic      illegal;
  } dec_t;

endpackage

// File: rtl/alu_exec_decode.sv
module alu_exec_decode
  import alu_exec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [FN_W-1:0]  fn_i,
  output dec_t             dec_o
);

  always_comb begin
    dec_o = '{op: ALU_NONE, imm_mode: IMM_NONE, illegal: 1'b0};
    unique case (opcode_i)
      OPC_RTYPE: begin
        unique case (fn_i)
          FN_ADD:  dec_o.op = ALU_ADD;
          FN_SUB:  dec_o.op = ALU_SUB;
          FN_SLT:  dec_o.op = ALU_SLT;
          FN_AND:  dec_o.op = ALU_AND;
          FN_OR:   dec_o.op = ALU_OR;
          FN_XOR:  dec_o.op = ALU_XOR;
          FN_NOR:  dec_o.op = ALU_NOR;
          default: dec_o.illegal = 1'b1;
        endcase
      end
      OPC_ADDI: dec_o = '{op: ALU_ADD, imm_mode: IMM_SEXT, illegal: 1'b0};
      OPC_SLTI: dec_o = '{op: ALU_SLT, imm_mode: IMM_SEXT, illegal: 1'b0};
      OPC_ANDI: dec_o = '{op: ALU_AND, imm_mode: IMM_ZEXT, illegal: 1'b0};
      OPC_ORI:  dec_o = '{op: ALU_OR,  imm_mode: IMM_ZEXT, illegal: 1'b0};
      OPC_XORI: dec_o = '{op: ALU_XOR, imm_mode: IMM_ZEXT, illegal: 1'b0};
      OPC_LUI:  dec_o = '{op: ALU_LUI, imm_mode: IMM_NONE, illegal: 1'b0};
      // address comes from the AGU; result stays zero
      OPC_LW, OPC_SW: dec_o = '{op: ALU_NONE, imm_mode: IMM_NONE, illegal: 1'b0};
      default:  dec_o.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/alu_exec_immext.sv
module alu_exec_immext
  import alu_exec_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 16
) (
  input  logic [IMM_W-1:0] imm_i,
  input  imm_mode_e        mode_i,
  output logic [XLEN-1:0]  sext_o,
  output logic [XLEN-1:0]  ext_o
);

  localparam int unsigned PAD_W = XLEN - IMM_W;

  logic [XLEN-1:0] zext;

  generate
    if (PAD_W > 0) begin : g_pad
      assign sext_o = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
      assign zext   = {{PAD_W{1'b0}}, imm_i};
    end else begin : g_trunc
      assign sext_o = imm_i[XLEN-1:0];
      assign zext   = imm_i[XLEN-1:0];
    end
  endgenerate

  always_comb begin
    unique case (mode_i)
      IMM_SEXT: ext_o = sext_o;
      IMM_ZEXT: ext_o = zext;
      default:  ext_o = '0;
    endcase
  end

endmodule

// File: rtl/alu_exec_core.sv
module alu_exec_core
  import alu_exec_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 16
) (
  input  alu_op_e          op_i,
  input  logic [XLEN-1:0]  a_i,
  input  logic [XLEN-1:0]  b_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [XLEN-1:0]  result_o
);

  localparam int unsigned LO_W = XLEN - IMM_W;

  logic            lt;
  logic [XLEN-1:0] sum, diff, upper;

  assign sum   = a_i + b_i;
  assign diff  = a_i - b_i;
  assign lt    = $signed(a_i) < $signed(b_i);
  assign upper = {imm_i, {LO_W{1'b0}}};

  always_comb begin
    unique case (op_i)
      ALU_ADD: result_o = sum;
      ALU_SUB: result_o = diff;
      ALU_SLT: result_o = {{(XLEN-1){1'b0}}, lt};
      ALU_AND: result_o = a_i & b_i;
      ALU_OR:  result_o = a_i | b_i;
      ALU_XOR: result_o = a_i ^ b_i;
      ALU_NOR: result_o = ~(a_i | b_i);
      ALU_LUI: result_o = upper;
      default: result_o = '0;
    endcase
  end

endmodule

// File: rtl/alu_exec_agu.sv
module alu_exec_agu #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] offset_i,
  output logic [XLEN-1:0] addr_o
);

  assign addr_o = base_i + offset_i;

endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu_exec_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 16
) (
  input  logic [5:0]       opcode_i,
  input  logic [5:0]       fn_i,
  input  logic [XLEN-1:0]  rs_val_i,
  input  logic [XLEN-1:0]  rt_val_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [XLEN-1:0]  result_o,
  output logic [XLEN-1:0]  addr_o,
  output logic             illegal_o
);

  dec_t            dec;
  logic [XLEN-1:0] imm_sext, imm_ext, operand_b;

  alu_exec_decode i_decode (
    .opcode_i (opcode_i),
    .fn_i     (fn_i),
    .dec_o    (dec)
  );

  alu_exec_immext #(.XLEN(XLEN), .IMM_W(IMM_W)) i_immext (
    .imm_i  (imm_i),
    .mode_i (dec.imm_mode),
    .sext_o (imm_sext),
    .ext_o  (imm_ext)
  );

  assign operand_b = (dec.imm_mode == IMM_NONE) ? rt_val_i : imm_ext;

  alu_exec_core #(.XLEN(XLEN), .IMM_W(IMM_W)) i_core (
    .op_i     (dec.op),
    .a_i      (rs_val_i),
    .b_i      (operand_b),
    .imm_i    (imm_i),
    .result_o (result_o)
  );

  alu_exec_agu #(.XLEN(XLEN)) i_agu (
    .base_i   (rs_val_i),
    .offset_i (imm_sext),
    .addr_o   (addr_o)
  );

  assign illegal_o = dec.illegal;

endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 16
) (
  input logic [5:0]       opcode_i,
  input logic [5:0]       fn_i,
  input logic [XLEN-1:0]  rs_val_i,
  input logic [XLEN-1:0]  rt_val_i,
  input logic [IMM_W-1:0] imm_i,
  input logic [XLEN-1:0]  result_o,
  input logic [XLEN-1:0]  addr_o,
  input logic             illegal_o
);

  logic [XLEN-1:0] offset;
  assign offset = addr_o - rs_val_i;

  always_comb begin
    // R8
    illegal_zero_chk: assert (!illegal_o || result_o == '0)
      else $error("illegal encoding produced nonzero result");
    // R6
    lui_layout_chk: assert (opcode_i != 6'd15 ||
                            (result_o[XLEN-1:XLEN-IMM_W] == imm_i &&
                             result_o[XLEN-IMM_W-1:0] == '0))
      else $error("upper-immediate layout wrong");
    // R3
    slt_bool_chk: assert (!((opcode_i == 6'd0 && fn_i == 6'd42) || opcode_i == 6'd10) ||
                          result_o[XLEN-1:1] == '0)
      else $error("set-less-than result not boolean");
    // R2
    nor_disjoint_chk: assert (!(opcode_i == 6'd0 && fn_i == 6'd39) ||
                              ((result_o & (rs_val_i | rt_val_i)) == '0 &&
                               (result_o | rs_val_i | rt_val_i) == '1))
      else $error("nor result not complement of or");
    // R7
    addr_offset_chk: assert (offset[IMM_W-1:0] == imm_i &&
                             ((&offset[XLEN-1:IMM_W-1]) || !(|offset[XLEN-1:IMM_W-1])))
      else $error("address offset not a sign-extended immediate");
    // R7
    mem_legal_chk: assert (!(opcode_i == 6'd35 || opcode_i == 6'd43) ||
                           (!illegal_o && result_o == '0))
      else $error("load/store flagged or nonzero result");
  end

endmodule

bind alu_exec alu_exec_chk #(.XLEN(XLEN), .IMM_W(IMM_W)) i_alu_exec_chk (
  .opcode_i  (opcode_i),
  .fn_i      (fn_i),
  .rs_val_i  (rs_val_i),
  .rt_val_i  (rt_val_i),
  .imm_i     (imm_i),
  .result_o  (result_o),
  .addr_o    (addr_o),
  .illegal_o (illegal_o)
);

// File: tb/test_alu_exec.sv
module test_alu_exec;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic [5:0]  opcode, fn;
  logic [31:0] rs_val, rt_val, result, addr;
  logic [15:0] imm;
  logic        illegal;
  int          n_vec  = 0;
  int          n_fail = 0;
  bit          done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_exec i_alu_exec (
    .opcode_i  (opcode),
    .fn_i      (fn),
    .rs_val_i  (rs_val),
    .rt_val_i  (rt_val),
    .imm_i     (imm),
    .result_o  (result),
    .addr_o    (addr),
    .illegal_o (illegal)
  );

  function automatic logic [31:0] pat32(int k);
    case (k % 6)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'h7FFF_FFFF;
      default: return 32'h1234_5678;
    endcase
  endfunction

  function automatic logic [15:0] pat16(int k);
    case (k % 6)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'hFFFF;
      3: return 16'h8000;
      4: return 16'h7FFF;
      default: return 16'h00F0;
    endcase
  endfunction

  function automatic string req_tag(logic [5:0] op, logic [5:0] f);
    if (op == 0) begin
      if (f == 32 || f == 34) return "R1";
      if (f >= 36 && f <= 39) return "R2";
      if (f == 42) return "R3";
      return "R8";
    end
    if (op == 8 || op == 10) return "R4";
    if (op >= 12 && op <= 14) return "R5";
    if (op == 15) return "R6";
    if (op == 35 || op == 43) return "R7";
    return "R8";
  endfunction

  // expected {illegal, result}, computed arithmetically
  function automatic logic [32:0] model(logic [5:0] op, logic [5:0] f,
                                        logic [31:0] a, logic [31:0] b, logic [15:0] im);
    longint sa, sb, sx;
    longint unsigned ua, ub, zx, m;
    m  = 64'h1_0000_0000;
    ua = longint'(a);
    ub = longint'(b);
    sa = (a >= 32'h8000_0000) ? longint'(a) - longint'(m) : longint'(a);
    sb = (b >= 32'h8000_0000) ? longint'(b) - longint'(m) : longint'(b);
    zx = longint'(im);
    sx = (im >= 16'h8000) ? longint'(im) - 65536 : longint'(im);
    if (op == 0) begin
      case (f)
        32: return {1'b0, 32'((ua + ub) % m)};
        34: return {1'b0, 32'((ua + m - ub) % m)};
        36: return {1'b0, a & b};
        37: return {1'b0, a | b};
        38: return {1'b0, a ^ b};
        39: return {1'b0, 32'(m - 1 - longint'(a | b))};
        42: return {1'b0, (sa < sb) ? 32'd1 : 32'd0};
        default: return {1'b1, 32'd0};
      endcase
    end
    case (op)
      8:  return {1'b0, 32'((longint'(ua) + sx + longint'(m)) % longint'(m))};
      10: return {1'b0, (sa < sx) ? 32'd1 : 32'd0};
      12: return {1'b0, 32'(ua & zx)};
      13: return {1'b0, 32'(ua | zx)};
      14: return {1'b0, 32'(ua ^ zx)};
      15: return {1'b0, 32'(zx * 65536)};
      35, 43: return {1'b0, 32'd0};
      default: return {1'b1, 32'd0};
    endcase
  endfunction

  task automatic apply(logic [5:0] op, logic [5:0] f,
                       logic [31:0] a, logic [31:0] b, logic [15:0] im);
    logic [32:0] exp;
    logic [31:0] exp_addr;
    longint sx;
    @(posedge clk);
    opcode = op; fn = f; rs_val = a; rt_val = b; imm = im;
    exp = model(op, f, a, b, im);
    sx = (im >= 16'h8000) ? longint'(im) - 65536 : longint'(im);
    exp_addr = 32'((longint'(a) + sx + 64'h1_0000_0000) % 64'h1_0000_0000);
    @(negedge clk);
    n_vec++;
    if ({illegal, result} !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d fn=%0d a=%h b=%h imm=%h: got ill=%b res=%h, expected ill=%b res=%h",
               req_tag(op, f), op, f, a, b, im, illegal, result, exp[32], exp[31:0]);
    end
    n_vec++;
    // R7 address generator on every encoding
    if (addr !== exp_addr) begin
      n_fail++;
      $display("FAIL R7 op=%0d a=%h imm=%h: got addr=%h, expected %h",
               op, a, im, addr, exp_addr);
    end
  endtask

  task automatic directed(string tag, logic [5:0] op, logic [5:0] f,
                          logic [31:0] a, logic [31:0] b, logic [15:0] im,
                          logic [31:0] exp_res);
    @(posedge clk);
    opcode = op; fn = f; rs_val = a; rt_val = b; imm = im;
    @(negedge clk);
    n_vec++;
    if (result !== exp_res) begin
      n_fail++;
      $display("FAIL %s directed op=%0d fn=%0d: got %h, expected %h", tag, op, f, result, exp_res);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG && !done) begin
        n_fail++;
        $display("FAIL watchdog expired after %0d cycles", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
      end
    end
  end

  initial begin
    opcode = 0; fn = 0; rs_val = 0; rt_val = 0; imm = 0;
    // idle state: opcode 0 fn 0 is unlisted (R8)
    @(negedge clk);
    n_vec++;
    if (illegal !== 1'b1 || result !== 32'd0) begin
      n_fail++;
      $display("FAIL R8 idle: got ill=%b res=%h, expected ill=1 res=0", illegal, result);
    end

    // R1 R2 R3 directed corners
    directed("R1", 6'd0, 6'd32, 32'hFFFF_FFFF, 32'h1, 16'h0, 32'h0);
    directed("R1", 6'd0, 6'd34, 32'h0, 32'h1, 16'h0, 32'hFFFF_FFFF);
    directed("R2", 6'd0, 6'd39, 32'h0, 32'h0, 16'h0, 32'hFFFF_FFFF);
    directed("R3", 6'd0, 6'd42, 32'h8000_0000, 32'h1, 16'h0, 32'h1);
    directed("R3", 6'd0, 6'd42, 32'h1, 32'hFFFF_FFFF, 16'h0, 32'h0);
    // R4 R5 R6 directed corners
    directed("R4", 6'd8, 6'd0, 32'h5, 32'h0, 16'hFFFF, 32'h4);
    directed("R4", 6'd10, 6'd0, 32'h0, 32'h0, 16'h8000, 32'h0);
    directed("R5", 6'd12, 6'd0, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 32'h0000_FFFF);
    directed("R5", 6'd14, 6'd0, 32'hFFFF_0000, 32'h0, 16'h8001, 32'hFFFF_8001);
    directed("R6", 6'd15, 6'd0, 32'hDEAD_BEEF, 32'h0, 16'h2110, 32'h2110_0000);
    directed("R7", 6'd35, 6'd0, 32'h1000, 32'h0, 16'hFFFC, 32'h0);

    // full opcode x function-code sweep (R8 and decode)
    for (int op = 0; op < 64; op++)
      for (int f = 0; f < 64; f++)
        apply(6'(op), 6'(f), pat32(op + f), pat32(op + 2 * f + 1), pat16(op * 3 + f));

    // every legal encoding against boundary operands
    for (int e = 0; e < 15; e++) begin
      logic [5:0] op, f;
      case (e)
        0: begin op = 0; f = 32; end
        1: begin op = 0; f = 34; end
        2: begin op = 0; f = 36; end
        3: begin op = 0; f = 37; end
        4: begin op = 0; f = 38; end
        5: begin op = 0; f = 39; end
        6: begin op = 0; f = 42; end
        7: begin op = 8; f = 0; end
        8: begin op = 10; f = 0; end
        9: begin op = 12; f = 0; end
        10: begin op = 13; f = 0; end
        11: begin op = 14; f = 0; end
        12: begin op = 15; f = 0; end
        13: begin op = 35; f = 0; end
        default: begin op = 43; f = 0; end
      endcase
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          for (int k = 0; k < 6; k++)
            apply(op, f, pat32(i), pat32(j), pat16(k));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule